// File: doc/BRIEF.md
# Sequential Maximal-Match Crossbar Scheduler

This block decides, for an N-by-N input-queued crossbar with per-destination queues at every input, which input sends to which output. At the start of a cell time it takes a snapshot of the occupancy count of every input/output queue. An input asks for an output only while that queue's count is above zero. The block then builds a conflict-free pairing by visiting one input row per clock cycle. Each visited input takes the lowest-numbered output that is still free and that it has cells for. A pairing, once made, is kept for the rest of the pass.

With a speedup of S, the pairing is built S times in each cell time. After every grant the scheduler lowers its local copy of that queue's count, so a later pass sees only the cells that are left. Each finished pass is reported as a grant matrix with its pass number. When the last pass completes, a done pulse marks the per-queue dequeue counts as final. The first input visited moves forward by one each cell time, so no input always gets first choice.

Top module: `xbar_maximal_sched`

## Requirements
- R1: A grant from input i to output j is issued in a pass only when the scheduler's count for that queue is non-zero at the start of that pass. The count for queue (i,j) is loaded from `occ_i[(i*N_PORTS+j)*CNT_W +: CNT_W]` on start.
- R2: In every reported grant matrix, each input row holds at most one set bit and each output column holds at most one set bit. Bit `grant_o[i*N_PORTS+j]` pairs input i with output j.
- R3: After each pass, no input without a grant still has a non-zero count toward an output without a grant.
- R4: Within a pass, inputs are visited in ascending order modulo N_PORTS, starting at the cell time's base input. Each visited input takes the lowest-indexed output that is still free and has a non-zero count. Its grant is never withdrawn.
- R5: The base input is 0 for the first cell time after reset and advances by one, wrapping, after every completed cell time.
- R6: A cell time runs SPEEDUP passes, numbered 0 to SPEEDUP-1 on `pass_idx_o`. Each grant decrements that queue's count before the next pass. `deq_o[(i*N_PORTS+j)*DEQ_W +: DEQ_W]` ends equal to the number of grants queue (i,j) received, never more than SPEEDUP or its occupancy. The value is held from done until the next start.
- R7: A start accepted at clock edge E0 raises `busy_o`. `grant_valid_o` pulses for one cycle after edges E(N_PORTS), E(2*N_PORTS), and so on up to E(SPEEDUP*N_PORTS). `done_o` pulses together with the last one, and `busy_o` falls at the same time.
- R8: `start_i` asserted while `busy_o` is high is ignored. It does not restart, lengthen or alter the running cell time.
- R9: While reset is asserted and after it is released, `busy_o`, `grant_valid_o`, `done_o`, `grant_o` and `deq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a cell time (taken only when idle) |
| occ_i | input | N_PORTS*N_PORTS*CNT_W | Queue occupancy counts, sampled on start |
| busy_o | output | 1 | Cell time in progress |
| grant_valid_o | output | 1 | One-cycle strobe: a pass finished |
| grant_o | output | N_PORTS*N_PORTS | Grant matrix of the last finished pass |
| pass_idx_o | output | PW | Number of the pass reported in grant_o |
| done_o | output | 1 | One-cycle strobe: all passes finished |
| deq_o | output | N_PORTS*N_PORTS*DEQ_W | Cells granted per queue this cell time |

## Verification
The bench drives a single column of requests from every input. A design that rearranged or dropped earlier pairings, or let one output serve two inputs, would give the wrong winner or a doubled column. A queue holding exactly one cell must be served once and then fall silent in the second pass; a scheduler that did not decrement between passes would grant it twice and report a dequeue count of two. The rotating base input is checked over many cell times, because a stuck pointer always favours the same row and shows up as an exact grant mismatch. Start pulses in the middle of a run are added to catch a controller that restarts or stretches the pass sequence.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_state_e;

endpackage

// File: rtl/sched_first_pick.sv
// Fixed-priority selector: the lowest-indexed asserted request wins.
module sched_first_pick #(
  parameter int N_PORTS = 4
) (
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] gnt_o
);

  logic [N_PORTS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar gj = 0; gj < N_PORTS; gj++) begin : g_chain
    assign gnt_o[gj]  = req_i[gj] & ~seen[gj];
    assign seen[gj+1] = seen[gj] | req_i[gj];
  end

endmodule

// File: rtl/sched_ctrl.sv
// Sequencer: walks one input row per cycle, SPEEDUP passes per cell time,
// and rotates the base row after every cell time.
module sched_ctrl
  import sched_pkg::*;
#(
  parameter  int N_PORTS = 4,
  parameter  int SPEEDUP = 2,
  localparam int SW      = $clog2(N_PORTS),
  localparam int PW      = (SPEEDUP > 1) ? $clog2(SPEEDUP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          row_en_o,
  output logic          pass_end_o,
  output logic          cell_end_o,
  output logic [SW-1:0] row_o,
  output logic [PW-1:0] pass_o
);

  sched_state_e  state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic [PW-1:0] pass_q, pass_d;
  logic [SW-1:0] base_q, base_d;
  logic          step_last;
  logic          pass_last;
  logic [SW:0]   row_sum;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    pass_d     = pass_q;
    base_d     = base_q;
    load_o     = (state_q == ST_IDLE) && start_i;
    row_en_o   = (state_q == ST_RUN);
    step_last  = (step_q == SW'(N_PORTS - 1));
    pass_last  = (pass_q == PW'(SPEEDUP - 1));
    pass_end_o = row_en_o && step_last;
    cell_end_o = pass_end_o && pass_last;

    if (load_o) begin
      state_d = ST_RUN;
      step_d  = '0;
      pass_d  = '0;
    end else if (row_en_o) begin
      if (step_last) begin
        step_d = '0;
        if (pass_last) begin
          state_d = ST_IDLE;
          pass_d  = '0;
          base_d  = (base_q == SW'(N_PORTS - 1)) ? '0 : base_q + 1'b1;
        end else begin
          pass_d = pass_q + 1'b1;
        end
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_comb begin
    row_sum = {1'b0, base_q} + {1'b0, step_q};
    if (row_sum >= (SW+1)'(N_PORTS)) begin
      row_o = SW'(row_sum - (SW+1)'(N_PORTS));
    end else begin
      row_o = row_sum[SW-1:0];
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign pass_o = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      pass_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      pass_q  <= pass_d;
      base_q  <= base_d;
    end
  end

endmodule

// File: rtl/sched_voq_bank.sv
// Local copy of every queue count plus the per-queue dequeue tally.
module sched_voq_bank #(
  parameter  int N_PORTS = 4,
  parameter  int CNT_W   = 4,
  parameter  int SPEEDUP = 2,
  localparam int SW      = $clog2(N_PORTS),
  localparam int DEQ_W   = $clog2(SPEEDUP + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_i,
  input  logic [N_PORTS*N_PORTS*CNT_W-1:0] occ_i,
  input  logic                             row_en_i,
  input  logic [SW-1:0]                    row_i,
  input  logic [N_PORTS-1:0]               pick_i,
  output logic [N_PORTS-1:0]               row_req_o,
  output logic [N_PORTS*N_PORTS*DEQ_W-1:0] deq_o
);

  logic [N_PORTS*N_PORTS-1:0] nz;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_row
    for (genvar gj = 0; gj < N_PORTS; gj++) begin : g_col
      localparam int IDX = gi * N_PORTS + gj;
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic [DEQ_W-1:0] deq_q, deq_d;
      logic             take;
      logic             cnt_en;

      assign take   = row_en_i && (row_i == SW'(gi)) && pick_i[gj];
      assign cnt_en = load_i || take;

      always_comb begin
        cnt_d = cnt_q;
        deq_d = deq_q;
        if (load_i) begin
          cnt_d = occ_i[IDX*CNT_W +: CNT_W];
          deq_d = '0;
        end else if (take) begin
          cnt_d = cnt_q - 1'b1;
          deq_d = deq_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          deq_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
          deq_q <= deq_d;
        end
      end

      assign nz[IDX]                     = |cnt_q;
      assign deq_o[IDX*DEQ_W +: DEQ_W]   = deq_q;
    end
  end

  always_comb begin
    row_req_o = '0;
    for (int r = 0; r < N_PORTS; r++) begin
      if (row_i == SW'(r)) begin
        row_req_o = nz[r*N_PORTS +: N_PORTS];
      end
    end
  end

endmodule

// File: rtl/xbar_maximal_sched.sv
// Crossbar scheduler: builds a maximal match one input row per cycle,
// SPEEDUP times per cell time.
module xbar_maximal_sched #(
  parameter  int N_PORTS = 4,
  parameter  int CNT_W   = 4,
  parameter  int SPEEDUP = 2,
  localparam int SW      = $clog2(N_PORTS),
  localparam int PW      = (SPEEDUP > 1) ? $clog2(SPEEDUP) : 1,
  localparam int DEQ_W   = $clog2(SPEEDUP + 1),
  localparam int NN      = N_PORTS * N_PORTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [NN*CNT_W-1:0]    occ_i,
  output logic                   busy_o,
  output logic                   grant_valid_o,
  output logic [NN-1:0]          grant_o,
  output logic [PW-1:0]          pass_idx_o,
  output logic                   done_o,
  output logic [NN*DEQ_W-1:0]    deq_o
);

  logic               load;
  logic               row_en;
  logic               pass_end;
  logic               cell_end;
  logic [SW-1:0]      row;
  logic [PW-1:0]      pass_cur;
  logic [N_PORTS-1:0] row_req;
  logic [N_PORTS-1:0] out_taken;
  logic [N_PORTS-1:0] pick;
  logic [NN-1:0]      match_q, match_d, match_add;
  logic [NN-1:0]      grant_q, grant_d;
  logic [PW-1:0]      pidx_q, pidx_d;
  logic               valid_q, done_q;

  sched_ctrl #(
    .N_PORTS (N_PORTS),
    .SPEEDUP (SPEEDUP)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .load_o     (load),
    .row_en_o   (row_en),
    .pass_end_o (pass_end),
    .cell_end_o (cell_end),
    .row_o      (row),
    .pass_o     (pass_cur)
  );

  sched_voq_bank #(
    .N_PORTS (N_PORTS),
    .CNT_W   (CNT_W),
    .SPEEDUP (SPEEDUP)
  ) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .occ_i     (occ_i),
    .row_en_i  (row_en),
    .row_i     (row),
    .pick_i    (pick),
    .row_req_o (row_req),
    .deq_o     (deq_o)
  );

  // Outputs already claimed in this pass.
  always_comb begin
    out_taken = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      out_taken = out_taken | match_q[i*N_PORTS +: N_PORTS];
    end
  end

  sched_first_pick #(
    .N_PORTS (N_PORTS)
  ) pick_i (
    .req_i (row_req & ~out_taken & {N_PORTS{row_en}}),
    .gnt_o (pick)
  );

  // Place the current row's grant into the match under construction.
  always_comb begin
    match_add = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (row_en && (row == SW'(i))) begin
        match_add[i*N_PORTS +: N_PORTS] = pick;
      end
    end
  end

  always_comb begin
    match_d = match_q;
    grant_d = grant_q;
    pidx_d  = pidx_q;
    if (load || pass_end) begin
      match_d = '0;
    end else if (row_en) begin
      match_d = match_q | match_add;
    end
    if (pass_end) begin
      grant_d = match_q | match_add;
      pidx_d  = pass_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (load || row_en) begin
      match_q <= match_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      pidx_q  <= '0;
    end else if (pass_end) begin
      grant_q <= grant_d;
      pidx_q  <= pidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= pass_end;
      done_q  <= cell_end;
    end
  end

  assign grant_valid_o = valid_q;
  assign grant_o       = grant_q;
  assign pass_idx_o    = pidx_q;
  assign done_o        = done_q;

endmodule

// File: rtl/xbar_maximal_sched_chk.sv
module xbar_maximal_sched_chk #(
  parameter  int N_PORTS = 4,
  parameter  int CNT_W   = 4,
  parameter  int SPEEDUP = 2,
  localparam int PW      = (SPEEDUP > 1) ? $clog2(SPEEDUP) : 1,
  localparam int DEQ_W   = $clog2(SPEEDUP + 1),
  localparam int NN      = N_PORTS * N_PORTS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_o,
  input logic                grant_valid_o,
  input logic [NN-1:0]       grant_o,
  input logic [PW-1:0]       pass_idx_o,
  input logic                done_o,
  input logic [NN*DEQ_W-1:0] deq_o
);

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_rows
    AST_ROW_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> $onehot0(grant_o[gi*N_PORTS +: N_PORTS])); // R2
  end

  for (genvar gj = 0; gj < N_PORTS; gj++) begin : g_cols
    logic [N_PORTS-1:0] col;
    always_comb begin
      for (int i = 0; i < N_PORTS; i++) begin
        col[i] = grant_o[i*N_PORTS + gj];
      end
    end
    AST_COL_ONE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> $onehot0(col)); // R2
  end

  for (genvar gk = 0; gk < NN; gk++) begin : g_deq
    AST_DEQ_WITHIN_SPEEDUP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(deq_o[gk*DEQ_W +: DEQ_W]) <= SPEEDUP)); // R6
  end

  AST_DONE_ON_LAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (grant_valid_o && (int'(pass_idx_o) == SPEEDUP - 1))); // R6

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> !grant_valid_o); // R7

endmodule

bind xbar_maximal_sched xbar_maximal_sched_chk #(
  .N_PORTS (N_PORTS),
  .CNT_W   (CNT_W),
  .SPEEDUP (SPEEDUP)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .grant_valid_o (grant_valid_o),
  .grant_o       (grant_o),
  .pass_idx_o    (pass_idx_o),
  .done_o        (done_o),
  .deq_o         (deq_o)
);

// File: tb/xbar_maximal_sched_tb_top.sv
module xbar_maximal_sched_tb_top;

  localparam int N  = 4;
  localparam int CW = 4;
  localparam int S  = 2;
  localparam int DW = $clog2(S + 1);
  localparam int PW = (S > 1) ? $clog2(S) : 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*N*CW-1:0] occ = '0;
  logic              busy, gvalid, done;
  logic [N*N-1:0]    grant;
  logic [PW-1:0]     pidx;
  logic [N*N*DW-1:0] deq;

  always #10 clk = ~clk;   // 50 MHz

  xbar_maximal_sched #(.N_PORTS(N), .CNT_W(CW), .SPEEDUP(S)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start), .occ_i (occ),
    .busy_o (busy), .grant_valid_o (gvalid), .grant_o (grant),
    .pass_idx_o (pidx), .done_o (done), .deq_o (deq)
  );

  int checks = 0;
  int errors = 0;
  int m_occ [N][N];
  int m_base = 0;
  bit [N*N-1:0] e_grant [S];
  int e_pre [S][N][N];
  int e_deq [N][N];

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic void build_model();
    int c [N][N];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        c[i][j] = m_occ[i][j];
        e_deq[i][j] = 0;
      end
    for (int p = 0; p < S; p++) begin
      bit [N-1:0] taken = '0;
      e_grant[p] = '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) e_pre[p][i][j] = c[i][j];
      for (int k = 0; k < N; k++) begin
        int r = (m_base + k) % N;
        bit got = 1'b0;
        for (int j = 0; j < N; j++) begin
          if (!got && !taken[j] && c[r][j] > 0) begin
            e_grant[p][r*N+j] = 1'b1;
            taken[j] = 1'b1;
            c[r][j]--;
            e_deq[r][j]++;
            got = 1'b1;
          end
        end
      end
    end
  endfunction

  task automatic check_pass(input int p);
    bit [N-1:0] rowany = '0;
    bit [N-1:0] colany = '0;
    bit ok_r1 = 1'b1, ok_r2 = 1'b1, ok_r3 = 1'b1;
    chk(int'(pidx) == p, $sformatf("R6 pass index act=%0d exp=%0d", pidx, p));
    chk(grant == e_grant[p],
        $sformatf("R4 R5 grant pass %0d act=%h exp=%h base=%0d", p, grant, e_grant[p], m_base));
    for (int i = 0; i < N; i++) begin
      int rc = 0;
      for (int j = 0; j < N; j++) begin
        if (grant[i*N+j]) begin
          rc++;
          rowany[i] = 1'b1;
          colany[j] = 1'b1;
          if (e_pre[p][i][j] == 0) ok_r1 = 1'b0;
        end
      end
      if (rc > 1) ok_r2 = 1'b0;
    end
    for (int j = 0; j < N; j++) begin
      int cc = 0;
      for (int i = 0; i < N; i++) if (grant[i*N+j]) cc++;
      if (cc > 1) ok_r2 = 1'b0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (!rowany[i] && !colany[j] && e_pre[p][i][j] > 0) ok_r3 = 1'b0;
    chk(ok_r1, $sformatf("R1 grant to empty queue act=%h exp=%h", grant, e_grant[p]));
    chk(ok_r2, $sformatf("R2 conflicting grants act=%h exp=%h", grant, e_grant[p]));
    chk(ok_r3, $sformatf("R3 match not maximal act=%h exp=%h", grant, e_grant[p]));
  endtask

  task automatic check_deq(input string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int a = int'(deq[(i*N+j)*DW +: DW]);
        chk(a == e_deq[i][j],
            $sformatf("R6 %s deq(%0d,%0d) act=%0d exp=%0d", tag, i, j, a, e_deq[i][j]));
      end
  endtask

  task automatic run_cell(input bit poke);
    build_model();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        occ[(i*N+j)*CW +: CW] = CW'(m_occ[i][j]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, $sformatf("R7 busy after start act=%0b exp=1", busy));
    for (int c = 1; c <= S*N + 2; c++) begin
      if (poke && c == 3) start = 1'b1;
      if (poke && c == 4) start = 1'b0;
      @(negedge clk);
      begin
        bit ev = ((c % N) == 0) && (c <= S*N);
        bit ed = (c == S*N);
        chk(gvalid == ev && done == ed,
            $sformatf("R7 strobes cycle %0d act=%0b%0b exp=%0b%0b", c, gvalid, done, ev, ed));
        if (gvalid && ev) check_pass(c / N - 1);
        if (c == S*N) check_deq("at done");
      end
    end
    chk(busy == 1'b0, $sformatf("R8 busy after cell time act=%0b exp=0", busy));
    if (poke) check_deq("held after ignored start");
    m_base = (m_base + 1) % N;
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) m_occ[i][j] = v;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(busy == 0 && gvalid == 0 && done == 0 && grant == '0 && deq == '0,
        $sformatf("R9 during reset act=%0b%0b%0b %h %h exp=0", busy, gvalid, done, grant, deq));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && gvalid == 0 && done == 0 && grant == '0 && deq == '0,
        $sformatf("R9 after reset act=%0b%0b%0b %h %h exp=0", busy, gvalid, done, grant, deq));

    fill(0);  run_cell(1'b0);                          // no requests
    fill(15); run_cell(1'b0);                          // every queue full
    fill(0);  for (int j = 0; j < N; j++) m_occ[0][j] = 1;
    run_cell(1'b0);                                    // one row, one cell each
    fill(0);  for (int i = 0; i < N; i++) m_occ[i][2] = 1;
    run_cell(1'b0);                                    // all inputs on one output
    fill(0);  for (int i = 0; i < N; i++) m_occ[i][i] = 1;
    run_cell(1'b1);                                    // diagonal, start poked mid-run

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          m_occ[i][j] = (($urandom % 2) == 0) ? 0 : int'($urandom % 4);
      run_cell((t % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule